// File: doc/BRIEF.md
# Two-Street Crossing Light Controller

This block sequences the signals at a crossing of two streets, called A and B, from one presence sensor per street. It is a four-phase Moore machine: A green, A yellow, B green, B yellow, visited always in that order. A street keeps its green for as long as its own sensor reports someone waiting or crossing. When that sensor drops, the street gets exactly one cycle of yellow, and then the other street turns green.

Each light is driven by a 2-bit code, and both codes are decoded from the current phase alone. A sensor change therefore never reaches the lights until the next rising clock edge. The reset is asynchronous and active low; it is expected to be released synchronously to the clock by the surrounding logic. It puts the crossing into the A-green phase.

The phase register uses a fixed binary encoding: A green is 00, A yellow is 01, B green is 10 and B yellow is 11. The block holds only the phase register, the next-phase logic and the light decoder.

Top module: `tl_crossing_ctrl`

## Requirements
- R1: While rst_n is low, light_a is green (00) and light_b is red (10), whatever the sensors do. The lights take these values as soon as rst_n falls.
- R2: In the A-green phase, a rising edge with sense_a = 1 keeps light_a green (00) and light_b red (10).
- R3: In the A-green phase, a rising edge with sense_a = 0 gives light_a yellow (01) and light_b red (10).
- R4: The A-yellow phase lasts exactly one cycle. The next edge gives light_a red (10) and light_b green (00), whatever the sensors are.
- R5: In the B-green phase, a rising edge with sense_b = 1 keeps light_a red (10) and light_b green (00).
- R6: In the B-green phase, a rising edge with sense_b = 0 gives light_a red (10) and light_b yellow (01).
- R7: The B-yellow phase lasts exactly one cycle. The next edge returns to light_a green (00) and light_b red (10), whatever the sensors are.
- R8: The lights depend only on the phase. A sensor change between clock edges leaves light_a and light_b unchanged until the next rising edge.
- R9: Code 11 never appears on either light, and in every cycle at least one street shows red (10).
- R10: sense_b has no effect while A is green, and sense_a has no effect while B is green.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the phase advances on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sense_a | input | 1 | Presence on street A (1 = occupied) |
| sense_b | input | 1 | Presence on street B (1 = occupied) |
| light_a | output | 2 | Light code for street A: 00 green, 01 yellow, 10 red |
| light_b | output | 2 | Light code for street B: 00 green, 01 yellow, 10 red |

## Verification
The bound checker checks the following on every clock edge, from the lights and sensors alone:
- the hold and leave rules of both green phases;
- the one-cycle length of both yellow phases and the phase that follows each;
- that code 11 never appears and that at least one street shows red.

Only the bench's scenarios can show:
- that the reset takes effect at once, without waiting for a clock edge, and overrides the sensors;
- that sensor changes in the middle of a cycle leave the lights alone;
- that the opposite street's sensor is ignored during a green phase (the bench toggles it while holding the active sensor high);
- that a reset asserted in the middle of a B-green phase brings A back to green.

// File: rtl/tl_pkg.sv
package tl_pkg;
  localparam int PHASE_W = 2;
  localparam int LIGHT_W = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_A_GO   = 2'b00,
    PH_A_WARN = 2'b01,
    PH_B_GO   = 2'b10,
    PH_B_WARN = 2'b11
  } phase_t;

  localparam logic [LIGHT_W-1:0] LT_GREEN  = 2'b00;
  localparam logic [LIGHT_W-1:0] LT_YELLOW = 2'b01;
  localparam logic [LIGHT_W-1:0] LT_RED    = 2'b10;
endpackage

// File: rtl/tl_next_phase.sv
module tl_next_phase
  import tl_pkg::*;
(
  input  phase_t cur,
  input  logic   sense_a,
  input  logic   sense_b,
  output phase_t nxt
);
  always_comb begin
    nxt = cur;
    unique case (cur)
      PH_A_GO:   nxt = sense_a ? PH_A_GO : PH_A_WARN;
      PH_A_WARN: nxt = PH_B_GO;
      PH_B_GO:   nxt = sense_b ? PH_B_GO : PH_B_WARN;
      PH_B_WARN: nxt = PH_A_GO;
      default:   nxt = PH_A_GO;
    endcase
  end
endmodule

// File: rtl/tl_phase_reg.sv
module tl_phase_reg
  import tl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t d,
  output phase_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= PH_A_GO;
    else        q <= d;
  end
endmodule

// File: rtl/tl_light_decode.sv
module tl_light_decode
  import tl_pkg::*;
(
  input  phase_t             cur,
  output logic [LIGHT_W-1:0] lamp_a,
  output logic [LIGHT_W-1:0] lamp_b
);
  always_comb begin
    lamp_a = LT_RED;
    lamp_b = LT_RED;
    unique case (cur)
      PH_A_GO:   begin lamp_a = LT_GREEN;  lamp_b = LT_RED;    end
      PH_A_WARN: begin lamp_a = LT_YELLOW; lamp_b = LT_RED;    end
      PH_B_GO:   begin lamp_a = LT_RED;    lamp_b = LT_GREEN;  end
      PH_B_WARN: begin lamp_a = LT_RED;    lamp_b = LT_YELLOW; end
      default:   begin lamp_a = LT_RED;    lamp_b = LT_RED;    end
    endcase
  end
endmodule

// File: rtl/tl_crossing_ctrl.sv
module tl_crossing_ctrl
  import tl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sense_a,
  input  logic               sense_b,
  output logic [LIGHT_W-1:0] light_a,
  output logic [LIGHT_W-1:0] light_b
);
  phase_t phase_q;
  phase_t phase_d;

  tl_next_phase u_next (
    .cur     (phase_q),
    .sense_a (sense_a),
    .sense_b (sense_b),
    .nxt     (phase_d)
  );

  tl_phase_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (phase_d),
    .q     (phase_q)
  );

  tl_light_decode u_dec (
    .cur    (phase_q),
    .lamp_a (light_a),
    .lamp_b (light_b)
  );
endmodule

// File: rtl/tl_crossing_chk.sv
module tl_crossing_chk
  import tl_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               sense_a,
  input logic               sense_b,
  input logic [LIGHT_W-1:0] light_a,
  input logic [LIGHT_W-1:0] light_b
);
  // R2 and R10: A green is held by sense_a, whatever sense_b is
  p_hold_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (light_a == LT_GREEN && sense_a) |=> (light_a == LT_GREEN && light_b == LT_RED));

  p_leave_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (light_a == LT_GREEN && !sense_a) |=> (light_a == LT_YELLOW && light_b == LT_RED));

  p_warn_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (light_a == LT_YELLOW) |=> (light_a == LT_RED && light_b == LT_GREEN));

  // R5 and R10: B green is held by sense_b, whatever sense_a is
  p_hold_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (light_b == LT_GREEN && sense_b) |=> (light_a == LT_RED && light_b == LT_GREEN));

  p_leave_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (light_b == LT_GREEN && !sense_b) |=> (light_a == LT_RED && light_b == LT_YELLOW));

  p_warn_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (light_b == LT_YELLOW) |=> (light_a == LT_GREEN && light_b == LT_RED));

  p_one_red_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (light_a != 2'b11 && light_b != 2'b11 && (light_a == LT_RED || light_b == LT_RED)));
endmodule

bind tl_crossing_ctrl tl_crossing_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sense_a (sense_a),
  .sense_b (sense_b),
  .light_a (light_a),
  .light_b (light_b)
);

// File: tb/tb_tl_crossing_ctrl.sv
`timescale 1ns/1ps
module tb_tl_crossing_ctrl;
  localparam logic [1:0] G = 2'b00;
  localparam logic [1:0] Y = 2'b01;
  localparam logic [1:0] R = 2'b10;

  logic       clk;
  logic       rst_n;
  logic       sense_a;
  logic       sense_b;
  logic [1:0] light_a;
  logic [1:0] light_b;

  int checks;
  int errors;
  bit done;

  tl_crossing_ctrl dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .sense_a (sense_a),
    .sense_b (sense_b),
    .light_a (light_a),
    .light_b (light_b)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic expect_lights(input logic [1:0] ea, input logic [1:0] eb,
                               input string req);
    checks++;
    if (light_a !== ea || light_b !== eb) begin
      errors++;
      $display("FAIL %s: light_a=%b light_b=%b expected light_a=%b light_b=%b",
               req, light_a, light_b, ea, eb);
    end
  endtask

  task automatic check_safe(input string req);
    checks++;
    if (light_a === 2'b11 || light_b === 2'b11 ||
        !(light_a === R || light_b === R)) begin
      errors++;
      $display("FAIL %s: light_a=%b light_b=%b expected no 11 and at least one red (10)",
               req, light_a, light_b);
    end
  endtask

  // Drive the sensors after a falling edge, then sample 1 ns after the next rising edge.
  task automatic step(input logic a, input logic b,
                      input logic [1:0] ea, input logic [1:0] eb, input string req);
    @(negedge clk);
    sense_a = a;
    sense_b = b;
    @(posedge clk);
    #1;
    expect_lights(ea, eb, req);
    check_safe("R9");
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    sense_a = 1'b0;
    sense_b = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    expect_lights(G, R, "R1 reset state");
    sense_a = 1'b1;
    sense_b = 1'b0;
    @(posedge clk);
    #1;
    expect_lights(G, R, "R1 sensors ignored during reset");
    @(negedge clk);
    sense_a = 1'b1;
    rst_n = 1'b1;
  endtask

  task automatic t_hold_a();
    step(1'b1, 1'b0, G, R, "R2 hold A");
    step(1'b1, 1'b1, G, R, "R10 sense_b ignored in A green");
    step(1'b1, 1'b0, G, R, "R10 sense_b dropped in A green");
  endtask

  task automatic t_a_to_b();
    step(1'b0, 1'b1, Y, R, "R3 A to yellow");
    step(1'b1, 1'b1, R, G, "R4 A yellow lasts one cycle");
  endtask

  task automatic t_hold_b();
    step(1'b0, 1'b1, R, G, "R5 hold B");
    step(1'b1, 1'b1, R, G, "R10 sense_a ignored in B green");
    step(1'b0, 1'b1, R, G, "R10 sense_a dropped in B green");
  endtask

  task automatic t_b_to_a();
    step(1'b1, 1'b0, R, Y, "R6 B to yellow");
    step(1'b0, 1'b1, G, R, "R7 B yellow lasts one cycle");
  endtask

  task automatic t_midcycle();
    @(negedge clk);
    sense_a = 1'b1;
    @(posedge clk);
    #1;
    expect_lights(G, R, "R8 settled in A green");
    #2;
    sense_a = 1'b0;
    #1;
    expect_lights(G, R, "R8 no change before edge");
    sense_a = 1'b1;
    #1;
    expect_lights(G, R, "R8 glitch on sensor ignored");
  endtask

  task automatic t_yellow_ignore_low();
    step(1'b0, 1'b0, Y, R, "R3 leave A with both sensors low");
    step(1'b0, 1'b0, R, G, "R4 A yellow with sensors low");
    step(1'b0, 1'b0, R, Y, "R6 leave B immediately");
    step(1'b1, 1'b1, G, R, "R7 B yellow with sensors high");
  endtask

  task automatic t_reset_mid();
    step(1'b0, 1'b1, Y, R, "R3 before mid reset");
    step(1'b0, 1'b1, R, G, "R4 before mid reset");
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    expect_lights(G, R, "R1 asynchronous reset from B green");
    @(negedge clk);
    sense_a = 1'b1;
    rst_n = 1'b1;
    step(1'b1, 1'b1, G, R, "R2 after reset release");
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    t_reset();
    t_hold_a();
    t_a_to_b();
    t_hold_b();
    t_b_to_a();
    t_midcycle();
    t_yellow_ignore_low();
    t_reset_mid();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule